// File: doc/BRIEF.md
# Gear-Mode System Clock Divider

This block turns a fast clock, which runs at twice the maximum system rate, into a divided family of system timing signals. It produces a two-phase system pair, an identical pair for the processor core domain, a bus-domain pair that can run at the same rate or at half of it, a synchronous pulse and a baud-rate reference pulse. Every output is a level or one-cycle enable that is aligned to the single fast clock, so downstream logic keeps one clock and gates on these signals.

Two 3-bit divide fields are held: one for full-speed operation and one for low-power operation. A mode input selects between them. Software may rewrite either field, the mode or the bus-ratio bit at any time. The block takes the new setting at the next point where phase 2 ends, so no phase is ever cut short or stretched partway through. The upstream clock source is never disturbed.

Top module: `gear_clk_div`

## Requirements
- R1: After reset `ph1` is high, `ph2` is low and `sync_en` is high. The divide is one, so each phase lasts one fast cycle.
- R2: `ph1` and `ph2` are never high together, and in every fast cycle exactly one of them is high.
- R3: An active field value n (0 to 7) makes each phase last 2^n fast cycles, so the output period is 2^(n+1) fast cycles.
- R4: With `mode_lp` low the active field is `div_hs`. With `mode_lp` high it is `div_lp`.
- R5: A change to `div_hs`, `div_lp`, `mode_lp` or `bus_half` takes effect from the first `ph1` cycle after the current `ph2` ends. The period in progress completes with the old setting.
- R6: `core_ph1` and `core_ph2` equal `ph1` and `ph2` in every cycle.
- R7: `sync_en` is high for exactly one fast cycle per period, the first cycle of `ph1`. `brg_en` is high for exactly one fast cycle per period, the first cycle of `ph2`.
- R8: With `bus_half` low (as taken at the boundary), `bus_ph1` and `bus_ph2` equal `ph1` and `ph2`.
- R9: With `bus_half` high, the bus pair follows the system pair only on alternate periods and stays low in the periods between. The first period after the setting is taken is an active one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Fast clock at twice the maximum system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_lp | input | 1 | 0 selects the full-speed field, 1 selects the low-power field |
| div_hs | input | FLD_W | Full-speed divide exponent |
| div_lp | input | FLD_W | Low-power divide exponent |
| bus_half | input | 1 | 1 runs the bus pair at half the system rate |
| ph1 | output | 1 | System phase 1 |
| ph2 | output | 1 | System phase 2 |
| core_ph1 | output | 1 | Core-domain phase 1 |
| core_ph2 | output | 1 | Core-domain phase 2 |
| bus_ph1 | output | 1 | Bus-domain phase 1 |
| bus_ph2 | output | 1 | Bus-domain phase 2 |
| sync_en | output | 1 | One-cycle pulse at the start of each period |
| brg_en | output | 1 | One-cycle pulse at the start of each phase 2 |

## Verification
The bench uses the default FLD_W of 3. This reaches the whole exponent range, including the largest ratio of 128 with its 256-cycle period, in a short run. Ratios are measured by counting phase widths from one `sync_en` to the next. Setting changes are made both at the very start of a period and in the middle of phase 2, which shows that the period in progress keeps the old width. The half-rate bus pattern is traced over several periods on entry and on exit.

// File: rtl/gear_clk_div.sv
module gear_clk_div #(
  parameter int FLD_W = 3
) (
  input  logic             clk_2x,
  input  logic             rst_n,
  input  logic             mode_lp,
  input  logic [FLD_W-1:0] div_hs,
  input  logic [FLD_W-1:0] div_lp,
  input  logic             bus_half,
  output logic             ph1,
  output logic             ph2,
  output logic             core_ph1,
  output logic             core_ph2,
  output logic             bus_ph1,
  output logic             bus_ph2,
  output logic             sync_en,
  output logic             brg_en
);
  localparam int CNT_W = 1 << FLD_W;

  logic [CNT_W-1:0] cnt;
  logic [FLD_W-1:0] cur_k;
  logic             half_q;
  logic             odd;
  logic [CNT_W:0]   half_w;
  logic             last;
  logic [FLD_W-1:0] sel_k;

  assign sel_k  = mode_lp ? div_lp : div_hs;
  assign half_w = (CNT_W+1)'(1) << cur_k;
  assign last   = ({1'b0, cnt} == ((half_w << 1) - (CNT_W+1)'(1)));

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cur_k  <= '0;
      half_q <= 1'b0;
      odd    <= 1'b0;
    end else if (last) begin
      cnt    <= '0;
      cur_k  <= sel_k;
      half_q <= bus_half;
      odd    <= bus_half & half_q & ~odd;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ph1      = ({1'b0, cnt} < half_w);
  assign ph2      = ~ph1;
  assign core_ph1 = ph1;
  assign core_ph2 = ph2;
  assign bus_ph1  = ph1 & ~odd;
  assign bus_ph2  = ph2 & ~odd;
  assign sync_en  = (cnt == '0);
  assign brg_en   = ({1'b0, cnt} == half_w);
endmodule

// File: rtl/gear_clk_div_chk.sv
module gear_clk_div_chk (
  input logic clk_2x,
  input logic rst_n,
  input logic ph1,
  input logic ph2,
  input logic bus_ph1,
  input logic bus_ph2,
  input logic sync_en,
  input logic brg_en
);
  // R2
  no_overlap_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) !(ph1 && ph2));
  // R2
  one_active_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) (ph1 || ph2));
  // R5
  ph1_after_ph2_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) $rose(ph1) |-> $past(ph2));
  // R7
  sync_start_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) $rose(ph1) |-> sync_en);
  // R7
  sync_in_ph1_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) sync_en |-> ph1);
  // R7
  brg_in_ph2_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) brg_en |-> ph2);
  // R9
  bus1_sub_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) bus_ph1 |-> ph1);
  // R9
  bus2_sub_chk: assert property (@(posedge clk_2x) disable iff (!rst_n) bus_ph2 |-> ph2);
endmodule

bind gear_clk_div gear_clk_div_chk chk_i (
  .clk_2x (clk_2x),
  .rst_n  (rst_n),
  .ph1    (ph1),
  .ph2    (ph2),
  .bus_ph1(bus_ph1),
  .bus_ph2(bus_ph2),
  .sync_en(sync_en),
  .brg_en (brg_en)
);

// File: tb/gear_clk_div_tb.sv
module gear_clk_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_lp = 1'b0;
  logic [2:0] div_hs = '0;
  logic [2:0] div_lp = '0;
  logic bus_half = 1'b0;
  logic ph1, ph2, core_ph1, core_ph2, bus_ph1, bus_ph2, sync_en, brg_en;

  int checks = 0;
  int fails = 0;
  int ovl = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  gear_clk_div #(.FLD_W(3)) dut_i (
    .clk_2x(clk), .rst_n(rst_n), .mode_lp(mode_lp), .div_hs(div_hs), .div_lp(div_lp),
    .bus_half(bus_half), .ph1(ph1), .ph2(ph2), .core_ph1(core_ph1), .core_ph2(core_ph2),
    .bus_ph1(bus_ph1), .bus_ph2(bus_ph2), .sync_en(sync_en), .brg_en(brg_en)
  );

  always @(negedge clk) if (rst_n && (ph1 === ph2)) ovl++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic sync_start();
    @(negedge clk);
    while (!sync_en) @(negedge clk);
  endtask

  task automatic run_period(output int n1, output int n2, output int b1, output int b2,
                            output int sp, output int bp, output int cm);
    n1 = 0; n2 = 0; b1 = 0; b2 = 0; sp = 0; bp = 0; cm = 0;
    while (ph1) begin
      n1++;
      if (bus_ph1) b1++;
      if (sync_en) sp++;
      if (brg_en) bp++;
      if (core_ph1 !== ph1 || core_ph2 !== ph2) cm++;
      @(negedge clk);
    end
    while (ph2) begin
      n2++;
      if (bus_ph2) b2++;
      if (sync_en) sp++;
      if (brg_en) bp++;
      if (core_ph1 !== ph1 || core_ph2 !== ph2) cm++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n1, n2, b1, b2, sp, bp, cm;
    chk(ph1 === 1'b1 && ph2 === 1'b0, "R1 reset phases", int'(ph1), 1);
    chk(sync_en === 1'b1, "R1 reset sync", int'(sync_en), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 1 && n2 == 1, "R1 divide by one", n1 * 10 + n2, 11);
  endtask

  task automatic t_ratio(input int k);
    int n1, n2, b1, b2, sp, bp, cm;
    div_hs = 3'(k);
    sync_start();
    run_period(n1, n2, b1, b2, sp, bp, cm);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == (1 << k) && n2 == (1 << k), "R3 phase width", n1, 1 << k);
    chk(sp == 1 && bp == 1, "R7 pulses per period", sp * 10 + bp, 11);
    chk(cm == 0, "R6 core pair match", cm, 0);
    chk(b1 == n1 && b2 == n2, "R8 bus pair full rate", b1 + b2, n1 + n2);
  endtask

  task automatic t_mode();
    int n1, n2, b1, b2, sp, bp, cm;
    div_hs = 3'd1; div_lp = 3'd4; mode_lp = 1'b0;
    sync_start();
    run_period(n1, n2, b1, b2, sp, bp, cm);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 2, "R4 full-speed field", n1, 2);
    mode_lp = 1'b1;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 2, "R5 mode change waits for boundary", n1, 2);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 16 && n2 == 16, "R4 low-power field", n1, 16);
    mode_lp = 1'b0;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 2, "R4 back to full-speed", n1, 2);
  endtask

  task automatic t_change();
    int n1, n2, b1, b2, sp, bp, cm;
    int rem;
    div_hs = 3'd3;
    sync_start();
    run_period(n1, n2, b1, b2, sp, bp, cm);
    div_hs = 3'd1;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 8 && n2 == 8, "R5 current period keeps old ratio", n1, 8);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 2 && n2 == 2, "R5 new ratio next period", n1, 2);
    div_hs = 3'd3;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    while (ph1) @(negedge clk);
    div_hs = 3'd0;
    rem = 0;
    while (ph2) begin rem++; @(negedge clk); end
    chk(rem == 8, "R5 change during ph2 keeps width", rem, 8);
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(n1 == 1 && n2 == 1, "R5 applied after ph2 end", n1, 1);
  endtask

  task automatic t_bus();
    int n1, n2, b1, b2, sp, bp, cm;
    div_hs = 3'd2; bus_half = 1'b0;
    sync_start();
    run_period(n1, n2, b1, b2, sp, bp, cm);
    bus_half = 1'b1;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    chk(b1 == 4 && b2 == 4, "R5 bus ratio waits for boundary", b1 + b2, 8);
    for (int p = 0; p < 4; p++) begin
      run_period(n1, n2, b1, b2, sp, bp, cm);
      chk(b1 == ((p % 2 == 0) ? 4 : 0) && b2 == b1, "R9 alternate bus periods",
          b1 + b2, (p % 2 == 0) ? 8 : 0);
    end
    bus_half = 1'b0;
    run_period(n1, n2, b1, b2, sp, bp, cm);
    for (int p = 0; p < 2; p++) begin
      run_period(n1, n2, b1, b2, sp, bp, cm);
      chk(b1 == 4 && b2 == 4, "R8 bus back to full rate", b1 + b2, 8);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ratio(2);
    t_ratio(5);
    t_ratio(7);
    t_ratio(0);
    t_mode();
    t_change();
    t_bus();
    chk(ovl == 0, "R2 phase exclusivity", ovl, 0);
    finish_run();
  end
endmodule